// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Staged Page Programming

This block is the bus-facing part of a small byte-addressed memory that is reached over a two-wire serial bus (I2C). It oversamples SCL and SDA with the system clock. It finds START and STOP conditions, matches a 7-bit device address, and serves three kinds of transfer: single-byte writes, page writes of up to 16 bytes, and sequential reads. SDA is open-drain. The block only reports when it wants the line pulled low, and the board or the bench forms the wired-AND.

Write data does not reach the 256-byte array while the transfer runs. Each received data byte is placed in a 16-entry page buffer. When STOP arrives, every buffered byte is copied into its page of the array in a single clock edge. A programming interval of a parameterised length then follows, with `busy_o` high. During that interval the block takes no part in any bus traffic. A host can poll the device address and wait for the first ACK to learn when programming has finished.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset, `busy_o` and `sda_pull_o` are low and every array byte reads as 0x00.
- R2: After a START, the block compares the first byte, MSB first, with `{DEV_ADDR, rw}`, where rw = 0 means write and rw = 1 means read. On a match it pulls SDA low during the ninth SCL clock. On a mismatch it never pulls SDA until the next START. It changes SDA only while SCL is low.
- R3: In a write, the byte after the device address is loaded into the 8-bit address pointer. Each following data byte is acknowledged and staged. The array is not changed and `busy_o` stays low until STOP.
- R4: After each staged data byte, only pointer bits [3:0] increment, wrapping 15 to 0, and bits [7:4] are held. When more than 16 bytes arrive, a later byte overwrites the staged entry it lands on.
- R5: A STOP that ends a write with at least one complete data byte commits every staged entry to its address in the selected page in one edge. Locations in that page that were not staged keep their contents. `busy_o` rises on the cycle after STOP is detected and stays high for exactly PROG_CYCLES clocks.
- R6: While `busy_o` is high, `sda_pull_o` stays low. A START with a matching address is not acknowledged.
- R7: In a read, the block drives the byte at the pointer MSB first, one bit per SCL low phase. It releases SDA for the master's acknowledge slot, and on a master ACK it continues with the next byte. The pointer increments across all 8 bits and wraps from 0xFF to 0x00. A repeated START keeps the pointer set by a preceding write-address phase.
- R8: On a master NACK, the block releases SDA and drives nothing more until a new START.
- R9: A STOP that arrives before any complete data byte starts no programming, and `busy_o` stays low.
- R10: A START in the middle of a byte aborts the transfer and discards the staged bytes: a following STOP does not program. The next transfer proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the wired bus |
| sda_pull_o | output | 1 | High to pull SDA low (open-drain enable) |
| busy_o | output | 1 | High during the programming interval |

## Verification
The bench builds the block with DEV_ADDR = 0x50 and PROG_CYCLES = 300. The shorter interval lets several complete write, program and read-back rounds fit in one run, and the checker counts the full busy window cycle by cycle. With an SCL quarter period of 8 system clocks, every synchroniser delay lands inside a single SCL low phase, so a late drive or release by the slave shows up as a wrong bit. Random page writes of up to 20 bytes at random addresses exercise the in-page wrap and the overwrite, and a read started at 0xFE covers the wrap of the full address space.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA
  } bus_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign sda_o      = sda_ff[1];
  assign scl_rise_o = scl_ff[1] & ~scl_q;
  assign scl_fall_o = ~scl_ff[1] & scl_q;
  assign start_o    = scl_ff[1] & scl_q & sda_q & ~sda_ff[1];
  assign stop_o     = scl_ff[1] & scl_q & ~sda_q & sda_ff[1];
endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int unsigned PROG_CYCLES = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(PROG_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= CW'(PROG_CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/page_store.sv
module page_store #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stage_clr_i,
  input  logic              stage_we_i,
  input  logic [PAGE_W-1:0] stage_idx_i,
  input  logic [7:0]        stage_data_i,
  input  logic              commit_i,
  input  logic [ADDR_W-PAGE_W-1:0] commit_page_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned PAGE  = 1 << PAGE_W;
  localparam int unsigned HI_W  = ADDR_W - PAGE_W;

  logic [7:0]      stage_q [PAGE];
  logic [PAGE-1:0] valid_q;
  logic [7:0]      mem_q   [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (stage_clr_i) begin
      valid_q <= '0;
    end else if (stage_we_i) begin
      valid_q[stage_idx_i] <= 1'b1;
    end
  end

  for (genvar p = 0; p < PAGE; p++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          stage_q[p] <= '0;
      else if (stage_we_i && stage_idx_i == PAGE_W'(p))      stage_q[p] <= stage_data_i;
    end
  end

  // one-edge commit of all staged entries into the selected page
  for (genvar a = 0; a < DEPTH; a++) begin : g_cell
    localparam logic [PAGE_W-1:0] IDX = PAGE_W'(a % PAGE);
    localparam logic [HI_W-1:0]   PG  = HI_W'(a / PAGE);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                            mem_q[a] <= '0;
      else if (commit_i && commit_page_i == PG && valid_q[IDX]) mem_q[a] <= stage_q[IDX];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/i2c_proto_fsm.sv
module i2c_proto_fsm
  import eeprom_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h50,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned PAGE_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              busy_i,
  input  logic [7:0]        rd_data_i,
  output logic              sda_pull_o,
  output logic              stage_clr_o,
  output logic              stage_we_o,
  output logic [PAGE_W-1:0] stage_idx_o,
  output logic [7:0]        stage_data_o,
  output logic              commit_o,
  output logic [ADDR_W-PAGE_W-1:0] commit_page_o,
  output logic [ADDR_W-1:0] ptr_o
);
  bus_st_e     st_q;
  logic [3:0]  bit_cnt_q;
  logic [7:0]  sh_q, tx_q, rx;
  logic        ack_q, have_data_q, pull_q;
  logic [ADDR_W-1:0] ptr_q;

  assign rx = {sh_q[6:0], sda_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; bit_cnt_q <= '0; sh_q <= '0; tx_q <= '0;
      ack_q <= 1'b0; have_data_q <= 1'b0; pull_q <= 1'b0; ptr_q <= '0;
      stage_clr_o <= 1'b0; stage_we_o <= 1'b0; stage_idx_o <= '0; stage_data_o <= '0;
    end else begin
      stage_clr_o <= 1'b0;
      stage_we_o  <= 1'b0;
      if (busy_i) begin
        st_q <= ST_IDLE; bit_cnt_q <= '0; pull_q <= 1'b0; have_data_q <= 1'b0;
      end else if (start_i) begin
        st_q <= ST_DEV; bit_cnt_q <= '0; pull_q <= 1'b0; have_data_q <= 1'b0;
      end else if (stop_i) begin
        st_q <= ST_IDLE; bit_cnt_q <= '0; pull_q <= 1'b0; have_data_q <= 1'b0;
      end else if (st_q != ST_IDLE) begin
        if (scl_rise_i) begin
          bit_cnt_q <= bit_cnt_q + 4'd1;
          if (bit_cnt_q < 4'd8) sh_q <= rx;
          if (bit_cnt_q == 4'd7) begin
            unique case (st_q)
              ST_DEV: begin
                ack_q <= (rx[7:1] == DEV_ADDR);
                if (rx[7:1] != DEV_ADDR) st_q <= ST_IDLE;
                else st_q <= rx[0] ? ST_RDATA : ST_WADDR;
              end
              ST_WADDR: begin
                ptr_q <= rx; stage_clr_o <= 1'b1; ack_q <= 1'b1; st_q <= ST_WDATA;
              end
              ST_WDATA: begin
                stage_we_o   <= 1'b1;
                stage_idx_o  <= ptr_q[PAGE_W-1:0];
                stage_data_o <= rx;
                ptr_q[PAGE_W-1:0] <= ptr_q[PAGE_W-1:0] + 1'b1;  // in-page wrap
                have_data_q  <= 1'b1;
                ack_q        <= 1'b1;
              end
              ST_RDATA: begin
                ptr_q <= ptr_q + 1'b1;  // full-space wrap
                ack_q <= 1'b0;
              end
              default: ;
            endcase
          end
          if (bit_cnt_q == 4'd8 && st_q == ST_RDATA && sda_i) st_q <= ST_IDLE;  // master NACK
        end else if (scl_fall_i) begin
          if (bit_cnt_q == 4'd8) begin
            pull_q <= ack_q;
          end else if (bit_cnt_q == 4'd9) begin
            bit_cnt_q <= '0;
            if (st_q == ST_RDATA) begin
              pull_q <= ~rd_data_i[7];
              tx_q   <= {rd_data_i[6:0], 1'b0};
            end else begin
              pull_q <= 1'b0;
            end
          end else if (st_q == ST_RDATA && bit_cnt_q != 4'd0) begin
            pull_q <= ~tx_q[7];
            tx_q   <= {tx_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign sda_pull_o    = pull_q;
  assign commit_o      = stop_i & have_data_q & ~busy_i;
  assign commit_page_o = ptr_q[ADDR_W-1:PAGE_W];
  assign ptr_o         = ptr_q;
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
  parameter logic [6:0]  DEV_ADDR    = 7'h50,
  parameter int unsigned PROG_CYCLES = 5000,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned PAGE_W      = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o,
  output logic busy_o
);
  localparam int unsigned HI_W = ADDR_W - PAGE_W;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic stage_clr, stage_we, commit;
  logic [PAGE_W-1:0] stage_idx;
  logic [7:0]        stage_data, rd_data;
  logic [HI_W-1:0]   commit_page;
  logic [ADDR_W-1:0] ptr;

  i2c_line_sync i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_proto_fsm #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_fsm (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .busy_i(busy_o), .rd_data_i(rd_data),
    .sda_pull_o, .stage_clr_o(stage_clr), .stage_we_o(stage_we),
    .stage_idx_o(stage_idx), .stage_data_o(stage_data), .commit_o(commit),
    .commit_page_o(commit_page), .ptr_o(ptr)
  );

  page_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_store (
    .clk_i, .rst_ni, .stage_clr_i(stage_clr), .stage_we_i(stage_we),
    .stage_idx_i(stage_idx), .stage_data_i(stage_data), .commit_i(commit),
    .commit_page_i(commit_page), .rd_addr_i(ptr), .rd_data_o(rd_data)
  );

  prog_timer #(.PROG_CYCLES(PROG_CYCLES)) i_timer (
    .clk_i, .rst_ni, .load_i(commit), .busy_o
  );
endmodule

// File: rtl/eeprom_i2c_checker.sv
module eeprom_i2c_checker #(
  parameter int unsigned PROG_CYCLES = 5000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_pull_o,
  input logic busy_o,
  input logic stop_det_i
);
  logic [31:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_cnt_q <= '0;
    else if (busy_o) hi_cnt_q <= hi_cnt_q + 1;
    else             hi_cnt_q <= '0;
  end

  a_r2_drive_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> !scl_i);

  a_r3_busy_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_det_i));

  a_r5_prog_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (hi_cnt_q == PROG_CYCLES));

  a_r6_quiet_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sda_pull_o);
endmodule

bind eeprom_i2c_slave eeprom_i2c_checker #(.PROG_CYCLES(PROG_CYCLES)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
  .busy_o(busy_o), .stop_det_i(stop_det)
);

// File: tb/test_eeprom_i2c_slave.sv
module test_eeprom_i2c_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int PROG       = 300;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, busy, sda_line;
  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [7:0] exp_mem [256];
  logic [7:0] wbuf [32];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  eeprom_i2c_slave #(.DEV_ADDR(DEV), .PROG_CYCLES(PROG)) i_eeprom_i2c_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .busy_o(busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp_v);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
    end
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); ack = ~sda_line; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl_m = 1'b1; qw(); b[i] = sda_line; qw(); scl_m = 1'b0;
    end
    qw(); sda_m = ~give_ack; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw(); sda_m = 1'b1;
  endtask

  task automatic model_write(input logic [7:0] addr, input int n);
    logic [7:0] a = addr;
    for (int i = 0; i < n; i++) begin
      exp_mem[a] = wbuf[i];
      a[3:0] = a[3:0] + 4'd1;
    end
  endtask

  task automatic do_write(input logic [7:0] addr, input int n);
    logic ack;
    i2c_start();
    wr_byte({DEV, 1'b0}, ack); check("R2 dev ack", ack, 1);
    wr_byte(addr, ack);        check("R3 addr ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      wr_byte(wbuf[i], ack);   check("R3 data ack", ack, 1);
    end
    check("R3 no busy before stop", busy, 0);
    i2c_stop();
    check("R5 busy after stop", busy, 1);
    model_write(addr, n);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    qw();
  endtask

  task automatic do_read(input logic [7:0] addr, input int n, input string req);
    logic ack;
    logic [7:0] b;
    logic [7:0] a = addr;
    i2c_start();
    wr_byte({DEV, 1'b0}, ack);
    wr_byte(addr, ack);
    i2c_start();
    wr_byte({DEV, 1'b1}, ack); check("R2 read dev ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i != n - 1, b);
      check(req, b, exp_mem[a]);
      a = a + 8'd1;
    end
    i2c_stop();
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    int unsigned seed;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
    seed = $urandom(32'h5eed_1234);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    qw();
    // R1
    check("R1 busy reset", busy, 0);
    check("R1 pull reset", sda_pull, 0);

    // R2 mismatching address: no ack, no drive
    i2c_start();
    wr_byte({7'h40, 1'b0}, ack); check("R2 mismatch nack", ack, 0);
    send_bits(8'h00, 8); check("R2 no drive after mismatch", sda_pull, 0);
    i2c_stop();

    // R9 STOP without data
    i2c_start();
    wr_byte({DEV, 1'b0}, ack); wr_byte(8'h10, ack);
    i2c_stop(); qw(); qw();
    check("R9 no program", busy, 0);

    // R3/R5/R6 byte write then poll while busy
    wbuf[0] = 8'h12;
    do_write(8'h35, 1);
    i2c_start();
    wr_byte({DEV, 1'b0}, ack); check("R6 nack while busy", ack, 0);
    i2c_stop();
    wait_idle();
    do_read(8'h30, 16, "R5 page content");

    // R4 page wrap with overwrite
    for (int i = 0; i < 18; i++) wbuf[i] = 8'hA0 + 8'(i);
    do_write(8'h4E, 18);
    wait_idle();
    do_read(8'h40, 16, "R4 in-page wrap");

    // R7 full-space wrap
    exp_mem[8'hFF] = 8'h00;
    do_read(8'hFE, 4, "R7 wrap 255->0");

    // R8 master NACK then silence
    i2c_start();
    wr_byte({DEV, 1'b0}, ack); wr_byte(8'h40, ack);
    i2c_start(); wr_byte({DEV, 1'b1}, ack);
    rd_byte(1'b0, b); check("R8 byte before nack", b, exp_mem[8'h40]);
    sda_m = 1'b1;
    for (int i = 0; i < 9; i++) begin
      qw(); scl_m = 1'b1; qw(); check("R8 released", sda_line, 1); qw(); scl_m = 1'b0; qw();
    end
    i2c_stop();

    // R10 START mid-byte discards staged data
    i2c_start();
    wr_byte({DEV, 1'b0}, ack); wr_byte(8'h80, ack); wr_byte(8'hAA, ack);
    send_bits(8'hF0, 4);
    i2c_start();
    i2c_stop(); qw(); qw();
    check("R10 aborted no program", busy, 0);
    do_read(8'h80, 1, "R10 array untouched");

    // random page writes
    for (int it = 0; it < 5; it++) begin
      logic [7:0] addr = 8'($urandom);
      int n = 1 + int'($urandom % 20);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      do_write(addr, n);
      wait_idle();
      do_read({addr[7:4], 4'h0}, 16, "R4 random page");
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule